// File: doc/BRIEF.md
# Conditional Execution Flag Evaluator

This block keeps the four processor status flags (negative, zero, carry, overflow) and decides, for each issued instruction, whether the instruction runs or is annulled. Each instruction comes with a four-bit condition code. The block tests that code against the flags as they stood before the instruction, and registers an execute decision one cycle later. The block also accepts a flag update from the arithmetic unit. That update is committed only when the instruction that carries it passes its condition.

Decode logic upstream presents `valid_i` together with `cond_i`. When the instruction is one that sets flags, it also presents `flag_we_i` and the new `flags_i`, all in the same cycle. Downstream logic uses `exec_o` to commit or discard the instruction's other effects. `flags_o` always shows the committed flags.

Top module: `cond_eval`

## Requirements
- R1: While `rst_ni` is low, the flags clear to 0000 and `exec_o` is low. Reset is asynchronous.
- R2: The flag bit positions are the same on `flags_i` and `flags_o`: bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R3: Code 1110 always passes, whatever the flags.
- R4: Code 1111 never passes. It also leaves the flags unchanged when `flag_we_i` is high.
- R5: The single-flag codes are: 0000 Z=1, 0001 Z=0, 0010 C=1, 0011 C=0, 0100 N=1, 0101 N=0, 0110 V=1, 0111 V=0.
- R6: The compound codes are: 1000 C=1 and Z=0, 1001 C=0 or Z=1, 1010 N==V, 1011 N!=V, 1100 Z=0 and N==V, 1101 Z=1 or N!=V.
- R7: The decision uses the flags held before the clock edge. A flag update presented in the same cycle does not affect that decision.
- R8: When the condition fails, `exec_o` is low in the next cycle and the requested flag update is dropped.
- R9: The flags load `flags_i` only at a clock edge where `valid_i`, `flag_we_i` and a passing condition all hold. `flag_we_i` without `valid_i` has no effect.
- R10: `exec_o` is registered. It is high in the cycle after a passing valid instruction and low in the cycle after any cycle with `valid_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is issued this cycle |
| cond_i | input | 4 | Condition code of the issued instruction |
| flag_we_i | input | 1 | The instruction requests a flag update |
| flags_i | input | 4 | New flag values {N,Z,C,V} |
| exec_o | output | 1 | Registered execute decision |
| flags_o | output | 4 | Committed flags {N,Z,C,V} |

## Verification
The hardest case to reach is a conditional instruction that also writes the flags and flips every flag in the same cycle. A wrong design could then take its decision from the new values, or commit an update that should be dropped. The stimulus covers this for all 256 pairs of flag value and condition code. It first loads a known flag value with an always-pass write. It then issues the code under test with a write of the bitwise complement of the current flags. The register must then hold either the old value or its complement, and the bench checks which one it holds.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int unsigned CondW = 4;
  localparam int unsigned FlagW = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [CondW-1:0] {
    C_ZS = 4'h0, C_ZC = 4'h1, C_CS = 4'h2, C_CC = 4'h3,
    C_NS = 4'h4, C_NC = 4'h5, C_VS = 4'h6, C_VC = 4'h7,
    C_HI = 4'h8, C_LS = 4'h9, C_GE = 4'hA, C_LT = 4'hB,
    C_GT = 4'hC, C_LE = 4'hD, C_AL = 4'hE, C_NV = 4'hF
  } cond_e;
endpackage

// File: rtl/cond_eval_decode.sv
module cond_eval_decode
  import cond_pkg::*;
(
  input  flags_t           flags_i,
  input  logic [CondW-1:0] cond_i,
  output logic             pass_o
);
  logic base;

  // codes come in pairs: even code tests, odd code inverts
  always_comb begin
    unique case (cond_i[CondW-1:1])
      3'd0: base = flags_i.z;
      3'd1: base = flags_i.c;
      3'd2: base = flags_i.n;
      3'd3: base = flags_i.v;
      3'd4: base = flags_i.c & ~flags_i.z;
      3'd5: base = ~(flags_i.n ^ flags_i.v);
      3'd6: base = ~flags_i.z & ~(flags_i.n ^ flags_i.v);
      default: base = 1'b1;
    endcase
  end

  assign pass_o = base ^ cond_i[0];
endmodule

// File: rtl/cond_eval_flags.sv
module cond_eval_flags
  import cond_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (upd_i) q_o <= d_i;
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [CondW-1:0] cond_i,
  input  logic             flag_we_i,
  input  logic [FlagW-1:0] flags_i,
  output logic             exec_o,
  output logic [FlagW-1:0] flags_o
);
  flags_t flags_q;
  logic   pass;
  logic   upd;
  logic   exec_q;

  cond_eval_decode u_decode (
    .flags_i (flags_q),
    .cond_i  (cond_i),
    .pass_o  (pass)
  );

  assign upd = valid_i & flag_we_i & pass;

  cond_eval_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .d_i    (flags_t'(flags_i)),
    .q_o    (flags_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exec_q <= 1'b0;
    else         exec_q <= valid_i & pass;
  end

  assign exec_o  = exec_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [3:0] cond_i,
  input logic       flag_we_i,
  input logic [3:0] flags_i,
  input logic       exec_o,
  input logic [3:0] flags_o
);
  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (flags_o == 4'h0 && !exec_o));

  p_always_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'hE) |=> exec_o);

  p_never_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'hF) |=> (!exec_o && $stable(flags_o)));

  p_zero_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'h0) |=> (exec_o == $past(flags_o[2])));

  p_signed_ge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'hA) |=> (exec_o == ($past(flags_o[3]) == $past(flags_o[0]))));

  p_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && flag_we_i) |=> (exec_o ? (flags_o == $past(flags_i)) : $stable(flags_o)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && flag_we_i) |=> $stable(flags_o));

  p_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !exec_o);
endmodule

bind cond_eval cond_eval_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .cond_i    (cond_i),
  .flag_we_i (flag_we_i),
  .flags_i   (flags_i),
  .exec_o    (exec_o),
  .flags_o   (flags_o)
);

// File: tb/cond_eval_tb_top.sv
module cond_eval_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] cond_i = 4'h0;
  logic       flag_we_i = 1'b0;
  logic [3:0] flags_i = 4'h0;
  logic       exec_o;
  logic [3:0] flags_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  cond_eval dut_i (
    .clk_i, .rst_ni, .valid_i, .cond_i, .flag_we_i, .flags_i, .exec_o, .flags_o
  );

  // flags {N,Z,C,V} = f[3:0] (R2)
  function automatic bit ref_pass(input logic [3:0] f, input logic [3:0] c);
    bit n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [3:0] c, input logic we, input logic [3:0] f);
    valid_i = v; cond_i = c; flag_we_i = we; flags_i = f;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0; flag_we_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    string tag;
    bit    p;
    repeat (3) @(negedge clk_i);
    check("R1 flags", flags_o, 4'h0);
    check("R1 exec", {3'b0, exec_o}, 4'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        issue(1'b1, 4'hE, 1'b1, f[3:0]);                 // load via always (R3)
        check("R2/R3 load", flags_o, f[3:0]);
        p = ref_pass(f[3:0], c[3:0]);
        if (c == 14)     tag = "R3";
        else if (c == 15) tag = "R4";
        else if (c < 8)  tag = "R5";
        else             tag = "R6";
        issue(1'b1, c[3:0], 1'b1, ~f[3:0]);              // same-cycle flip (R7)
        check({tag, "/R7 exec"}, {3'b0, exec_o}, {3'b0, p});
        check({tag, "/R8 flags"}, flags_o, p ? ~f[3:0] : f[3:0]);
        issue(1'b0, c[3:0], 1'b1, 4'h5);                 // write without valid (R9)
        check("R9 hold", flags_o, p ? ~f[3:0] : f[3:0]);
        check("R10 idle exec", {3'b0, exec_o}, 4'h0);
      end
    end

    issue(1'b1, 4'hE, 1'b1, 4'hF);
    rst_ni = 1'b0;
    #1;
    check("R1 async flags", flags_o, 4'h0);
    check("R1 async exec", {3'b0, exec_o}, 4'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule